// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block is the timekeeping core of a real-time clock. It divides a 32.768 kHz reference clock down to one strobe per second and uses that strobe to advance a calendar. The calendar holds seconds, minutes, hours, a weekday, a day of the month, a month and a three-digit year. Every field is stored as BCD digits, so software reads the values directly with no conversion. The month runs from 1 to 12. The year counts from 1900, so a stored year of 000 means 1900 and 124 means 2024. February follows the full Gregorian leap rule.

Software uses a small register port. It selects a field with a 3-bit address, reads that field combinationally, and writes it with a one-cycle write strobe. Writes take effect only while the enable input is high. When enable rises from 0 to 1, the seconds divider starts again from zero. While enable is low, the divider and the calendar both hold their values. The one-second strobe is also brought out so that neighbouring alarm logic can compare against the time on the same edge.

Top module: `bcd_timekeeper`

## Requirements
- R1: Take the clock edge that first samples `cal_enable` high after it was low. On the DIV_COUNT-th edge after that one, the seconds field advances. `sec_pulse` is high for the single cycle just before that edge. After that, the field advances once every DIV_COUNT cycles.
- R2: While `cal_enable` is low, `sec_pulse` stays low, the divider holds its count and no time field changes.
- R3: Seconds go from 59 to 00 and carry into minutes. Minutes go from 59 to 00 and carry into hours. Hours go from 23 to 00.
- R4: Each time the hour wraps from 23 to 00, the weekday (values 0 to 6) increments, and 6 wraps back to 0.
- R5: The day of the month goes back to 01 and the month advances once the day reaches the month's last day. January, March, May, July, August, October and December have 31 days. April, June, September and November have 30.
- R6: February has 29 days when the full year (1900 plus the stored count) is divisible by 4 and is either not divisible by 100 or divisible by 400. Otherwise it has 28.
- R7: After December 31, the date becomes January 01 and the 3-digit BCD year increments with decimal carries. A year of 999 wraps to 000.
- R8: A write while `cal_enable` is low changes no field.
- R9: A write that lands on the same edge as a one-second advance loads the written value into the addressed field. Every other field still advances and carries normally.
- R10: The field addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month (BCD 01 to 12) and 6 year. The year has the hundreds digit in bits [11:8] and the tens and units digits in bits [7:0]. Address 7 and any unused high bits read as zero. After reset the time is year 000, month 01, day 01, weekday 0, 00:00:00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_enable | input | 1 | Global run and write-enable bit |
| wr_en | input | 1 | Write strobe for the addressed field |
| addr | input | ADDR_W | Field select for both reading and writing |
| wr_data | input | 12 | BCD value to write |
| rd_data | output | 12 | BCD value of the addressed field |
| sec_pulse | output | 1 | One-cycle strobe before each second advance |

## Verification
A wrong divider count shows up within one second period as a strobe that is early or late. The bench checks the strobe and the seconds value on the exact cycles around the first two advances after a restart. A wrong carry or month-length decision only becomes visible at the moment of a rollover. For that reason, each rollover case first loads the time to the second before the boundary and then reads the fields on the edge just after the advance. That way a wrong day, month, year or weekday appears in the very next read. A write that slips past the enable gate shows up at once as a changed field while the clock is stopped.

// File: rtl/tk_pkg.sv
// Package: shared calendar types, field addresses and reset value.
// Assumes all fields hold valid BCD; widths are fixed by the BCD format.
package tk_pkg;
    localparam int TK_DATA_W    = 12;
    localparam int TK_NUM_FIELDS = 7;

    localparam int FLD_SEC  = 0;
    localparam int FLD_MIN  = 1;
    localparam int FLD_HOUR = 2;
    localparam int FLD_WDAY = 3;
    localparam int FLD_MDAY = 4;
    localparam int FLD_MON  = 5;
    localparam int FLD_YEAR = 6;

    typedef struct packed {
        logic [11:0] year;
        logic [7:0]  mon;
        logic [7:0]  mday;
        logic [2:0]  wday;
        logic [7:0]  hours;
        logic [7:0]  mins;
        logic [7:0]  sec;
    } tk_time_t;

    localparam tk_time_t TK_RESET_TIME = '{year: 12'h000, mon: 8'h01, mday: 8'h01,
                                           wday: 3'd0, hours: 8'h00, mins: 8'h00,
                                           sec: 8'h00};
endpackage

// File: rtl/tk_sec_divider.sv
// Module: one-second divider. Counts DIV_COUNT reference cycles while
// enabled and raises tick in the last cycle of each period. A rising enable
// restarts the count from zero; a low enable freezes it.
module tk_sec_divider #(
    parameter int DIV_COUNT = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);
    localparam int CW = (DIV_COUNT > 2) ? $clog2(DIV_COUNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);

    logic [CW-1:0] cnt;
    logic          en_q;

    // Count reference cycles, restarting on enable rise, holding when off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            en_q <= 1'b0;
        end else begin
            en_q <= enable;
            if (enable && !en_q)
                cnt <= '0;
            else if (enable)
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // Strobe in the final cycle of a running period.
    assign tick = enable && en_q && (cnt == LAST);

    a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(cnt));
endmodule

// File: rtl/tk_bcd_incr.sv
// Module: adds one to a packed BCD number of DIGITS digits. Each digit
// rolls from 9 to 0 and carries into the next. Assumes valid BCD input.
module tk_bcd_incr #(
    parameter int DIGITS = 2
) (
    input  logic [4*DIGITS-1:0] value,
    output logic [4*DIGITS-1:0] incd
);
    localparam logic [4*DIGITS-1:0] NINES = {DIGITS{4'h9}};

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic       carry_in;
        logic [3:0] dig;
        // A digit steps when every lower digit is nine.
        if (i == 0) begin : g_lsd
            assign carry_in = 1'b1;
        end else begin : g_upper
            assign carry_in = (value[4*i-1:0] == NINES[4*i-1:0]);
        end
        assign dig = value[4*i +: 4];
        assign incd[4*i +: 4] = !carry_in ? dig : ((dig == 4'h9) ? 4'h0 : dig + 4'h1);
    end
endmodule

// File: rtl/tk_month_len.sv
// Module: last day of a BCD month, with February depending on the Gregorian
// leap rule applied to 1900 plus the stored 3-digit BCD year.
// Only the low two year digits and the low two bits of the hundreds digit
// are needed: 1900 is divisible by 4, and 1900+Y is a multiple of 400
// exactly when Y is a whole hundred whose digit is 1, 5 or 9.
module tk_month_len (
    input  logic [7:0] mon,
    input  logic [7:0] year_lo,
    input  logic [1:0] cent_lo,
    output logic [7:0] last_day
);
    logic [4:0] mod_sum;
    logic       div4, whole_century, div400, leap;

    // (10*tens + units) mod 4 equals (2*tens + units) mod 4.
    assign mod_sum       = {year_lo[7:4], 1'b0} + {1'b0, year_lo[3:0]};
    assign div4          = (mod_sum[1:0] == 2'b00);
    assign whole_century = (year_lo == 8'h00);
    assign div400        = (cent_lo == 2'b01);
    assign leap          = div4 && (!whole_century || div400);

    // Select month length.
    always_comb begin
        case (mon)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcd_timekeeper.sv
// Module: BCD calendar time counter (top). Holds the time in BCD, advances
// it on each one-second tick with per-field carries, and serves a simple
// field read/write port. Writes are gated by cal_enable; a write on a tick
// edge wins for its own field only. Assumes software writes valid BCD.
module bcd_timekeeper
    import tk_pkg::*;
#(
    parameter int DIV_COUNT = 32768,
    parameter int ADDR_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cal_enable,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [TK_DATA_W-1:0] wr_data,
    output logic [TK_DATA_W-1:0] rd_data,
    output logic                 sec_pulse
);
    tk_time_t cur, adv, nxt;
    logic     tick;
    logic [TK_NUM_FIELDS-1:0] wr_hit;
    logic [7:0]  sec_inc, min_inc, hour_inc, mday_inc, mon_inc, last_day;
    logic [11:0] year_inc;
    logic sec_end, min_end, hour_end, day_end, mon_end, year_end;

    tk_sec_divider #(.DIV_COUNT(DIV_COUNT)) u_div (
        .clk(clk), .rst_n(rst_n), .enable(cal_enable), .tick(tick));

    tk_bcd_incr #(.DIGITS(2)) u_inc_sec  (.value(cur.sec),   .incd(sec_inc));
    tk_bcd_incr #(.DIGITS(2)) u_inc_min  (.value(cur.mins),  .incd(min_inc));
    tk_bcd_incr #(.DIGITS(2)) u_inc_hour (.value(cur.hours), .incd(hour_inc));
    tk_bcd_incr #(.DIGITS(2)) u_inc_mday (.value(cur.mday),  .incd(mday_inc));
    tk_bcd_incr #(.DIGITS(2)) u_inc_mon  (.value(cur.mon),   .incd(mon_inc));
    tk_bcd_incr #(.DIGITS(3)) u_inc_year (.value(cur.year),  .incd(year_inc));

    tk_month_len u_mlen (
        .mon(cur.mon), .year_lo(cur.year[7:0]), .cent_lo(cur.year[9:8]),
        .last_day(last_day));

    // Decode one write-hit line per field, gated by the enable bit.
    for (genvar f = 0; f < TK_NUM_FIELDS; f++) begin : g_hit
        assign wr_hit[f] = wr_en && cal_enable && (addr == ADDR_W'(f));
    end

    assign sec_end  = (cur.sec == 8'h59);
    assign min_end  = (cur.mins == 8'h59);
    assign hour_end = (cur.hours == 8'h23);
    assign day_end  = sec_end && min_end && hour_end;
    assign mon_end  = (cur.mday >= last_day);
    assign year_end = (cur.mon >= 8'h12);

    // Advance the calendar by one second with cascaded carries.
    always_comb begin
        adv = cur;
        if (tick) begin
            adv.sec = sec_end ? 8'h00 : sec_inc;
            if (sec_end)
                adv.mins = min_end ? 8'h00 : min_inc;
            if (sec_end && min_end)
                adv.hours = hour_end ? 8'h00 : hour_inc;
            if (day_end) begin
                adv.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
                adv.mday = mon_end ? 8'h01 : mday_inc;
                if (mon_end) begin
                    adv.mon = year_end ? 8'h01 : mon_inc;
                    if (year_end)
                        adv.year = year_inc;
                end
            end
        end
    end

    // Overlay software writes on the advanced time, field by field.
    always_comb begin
        nxt = adv;
        if (wr_hit[FLD_SEC])  nxt.sec   = {1'b0, wr_data[6:0]};
        if (wr_hit[FLD_MIN])  nxt.mins  = {1'b0, wr_data[6:0]};
        if (wr_hit[FLD_HOUR]) nxt.hours = {2'b00, wr_data[5:0]};
        if (wr_hit[FLD_WDAY]) nxt.wday  = wr_data[2:0];
        if (wr_hit[FLD_MDAY]) nxt.mday  = {2'b00, wr_data[5:0]};
        if (wr_hit[FLD_MON])  nxt.mon   = {3'b000, wr_data[4:0]};
        if (wr_hit[FLD_YEAR]) nxt.year  = wr_data[11:0];
    end

    // Time register.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= TK_RESET_TIME;
        else        cur <= nxt;
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_W'(FLD_SEC):  rd_data[7:0] = cur.sec;
            ADDR_W'(FLD_MIN):  rd_data[7:0] = cur.mins;
            ADDR_W'(FLD_HOUR): rd_data[7:0] = cur.hours;
            ADDR_W'(FLD_WDAY): rd_data[2:0] = cur.wday;
            ADDR_W'(FLD_MDAY): rd_data[7:0] = cur.mday;
            ADDR_W'(FLD_MON):  rd_data[7:0] = cur.mon;
            ADDR_W'(FLD_YEAR): rd_data      = cur.year;
            default:           rd_data      = '0;
        endcase
    end

    assign sec_pulse = tick;

    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick && sec_end && !wr_hit[FLD_SEC] |=> cur.sec == 8'h00);
    a_r3_hour_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick && day_end && !wr_hit[FLD_HOUR] |=> cur.hours == 8'h00);
    a_r4_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick && day_end && cur.wday == 3'd6 && !wr_hit[FLD_WDAY] |=> cur.wday == 3'd0);
    a_r7_new_year: assert property (@(posedge clk) disable iff (!rst_n)
        tick && day_end && cur.mon == 8'h12 && cur.mday == 8'h31
        && !wr_hit[FLD_MON] && !wr_hit[FLD_MDAY] |=> cur.mon == 8'h01 && cur.mday == 8'h01);
    a_r8_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_enable |=> $stable(cur));
    a_r9_sec_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit[FLD_SEC] |=> cur.sec == {1'b0, $past(wr_data[6:0])});
endmodule

// File: tb/bcd_timekeeper_bench.sv
`timescale 1ns/1ps
module bcd_timekeeper_bench;
    localparam int DIV = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_enable = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [11:0] wr_data = 12'h000;
    logic [11:0] rd_data;
    logic        sec_pulse;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    bcd_timekeeper #(.DIV_COUNT(DIV), .ADDR_W(3)) u_bcd_timekeeper (
        .clk(clk), .rst_n(rst_n), .cal_enable(cal_enable), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .sec_pulse(sec_pulse));

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input int f, output logic [11:0] v);
        addr = 3'(f);
        #1;
        v = rd_data;
    endtask

    task automatic wr(input int f, input logic [11:0] d);
        addr = 3'(f); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Packs all seven fields, year in the top 12 bits.
    task automatic read_all(output logic [63:0] t);
        logic [11:0] s, mi, h, wd, md, mo, y;
        rd(0, s); rd(1, mi); rd(2, h); rd(3, wd); rd(4, md); rd(5, mo); rd(6, y);
        t = {4'h0, y, md[7:0], mo[7:0], wd[7:0], h[7:0], mi[7:0], s[7:0]};
    endtask

    function automatic logic [63:0] tm(input logic [11:0] y, input logic [7:0] mo,
            input logic [7:0] md, input logic [7:0] wd, input logic [7:0] h,
            input logic [7:0] mi, input logic [7:0] s);
        return {4'h0, y, md, mo, wd, h, mi, s};
    endfunction

    // Restarts the divider and loads a full time; ends 7 edges after the restart edge.
    task automatic set_time(input logic [11:0] y, input logic [7:0] mo, input logic [7:0] md,
            input logic [7:0] wd, input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
        cal_enable = 1'b0;
        @(negedge clk);
        cal_enable = 1'b1;
        wr(6, y); wr(5, {4'h0, mo}); wr(4, {4'h0, md}); wr(3, {4'h0, wd});
        wr(2, {4'h0, h}); wr(1, {4'h0, mi}); wr(0, {4'h0, s});
    endtask

    task automatic step_second();
        while (sec_pulse !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic roll(input string req, input logic [63:0] start, input logic [63:0] exp);
        logic [63:0] t;
        set_time(start[59:48], start[39:32], start[47:40], start[31:24],
                 start[23:16], start[15:8], start[7:0]);
        step_second();
        read_all(t);
        chk(req, t, exp);
    endtask

    task automatic t_reset();
        logic [63:0] t;
        logic [11:0] v;
        read_all(t);
        chk("R10 reset time", t, tm(12'h000, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
        chk("R2 no pulse after reset", 64'(sec_pulse), 64'd0);
        rd(7, v);
        chk("R10 address 7 reads zero", 64'(v), 64'd0);
    endtask

    task automatic t_divider();
        logic [11:0] v;
        set_time(12'h124, 8'h06, 8'h15, 8'h02, 8'h08, 8'h00, 8'h10);
        repeat (8) @(negedge clk);
        chk("R1 no pulse before last count", 64'(sec_pulse), 64'd0);
        @(negedge clk);
        rd(0, v);
        chk("R1 pulse in last cycle", 64'(sec_pulse), 64'd1);
        chk("R1 seconds not yet advanced", 64'(v), 64'h10);
        @(negedge clk);
        rd(0, v);
        chk("R1 first advance", 64'(v), 64'h11);
        repeat (DIV - 1) @(negedge clk);
        rd(0, v);
        chk("R1 second period pulse", 64'(sec_pulse), 64'd1);
        chk("R1 second period hold", 64'(v), 64'h11);
        @(negedge clk);
        rd(0, v);
        chk("R1 second advance", 64'(v), 64'h12);
    endtask

    task automatic t_off();
        logic [63:0] t;
        int pulses = 0;
        set_time(12'h124, 8'h06, 8'h15, 8'h02, 8'h10, 8'h20, 8'h30);
        cal_enable = 1'b0;
        wr(0, 12'h005); wr(2, 12'h007); wr(6, 12'h321);
        for (int i = 0; i < 3 * DIV; i++) begin
            @(negedge clk);
            if (sec_pulse) pulses++;
        end
        chk("R2 no pulse while off", 64'(pulses), 64'd0);
        read_all(t);
        chk("R8 writes ignored, R2 time frozen", t,
            tm(12'h124, 8'h06, 8'h15, 8'h02, 8'h10, 8'h20, 8'h30));
    endtask

    task automatic t_carries();
        roll("R3 minute carry", tm(12'h124, 8'h06, 8'h15, 8'h03, 8'h10, 8'h59, 8'h59),
             tm(12'h124, 8'h06, 8'h15, 8'h03, 8'h11, 8'h00, 8'h00));
        roll("R3 R4 midnight weekday wrap", tm(12'h124, 8'h06, 8'h15, 8'h06, 8'h23, 8'h59, 8'h59),
             tm(12'h124, 8'h06, 8'h16, 8'h00, 8'h00, 8'h00, 8'h00));
        roll("R4 weekday step", tm(12'h124, 8'h06, 8'h16, 8'h02, 8'h23, 8'h59, 8'h59),
             tm(12'h124, 8'h06, 8'h17, 8'h03, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_months();
        roll("R5 April 30", tm(12'h124, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59),
             tm(12'h124, 8'h05, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00));
        roll("R5 May 30", tm(12'h124, 8'h05, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59),
             tm(12'h124, 8'h05, 8'h31, 8'h02, 8'h00, 8'h00, 8'h00));
        roll("R5 January 31", tm(12'h124, 8'h01, 8'h31, 8'h01, 8'h23, 8'h59, 8'h59),
             tm(12'h124, 8'h02, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_leap();
        roll("R6 2024 Feb 28", tm(12'h124, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59),
             tm(12'h124, 8'h02, 8'h29, 8'h02, 8'h00, 8'h00, 8'h00));
        roll("R6 2024 Feb 29", tm(12'h124, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59),
             tm(12'h124, 8'h03, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00));
        roll("R6 2023 Feb 28", tm(12'h123, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59),
             tm(12'h123, 8'h03, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00));
        roll("R6 1900 Feb 28", tm(12'h000, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59),
             tm(12'h000, 8'h03, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00));
        roll("R6 2000 Feb 28", tm(12'h100, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59),
             tm(12'h100, 8'h02, 8'h29, 8'h02, 8'h00, 8'h00, 8'h00));
        roll("R6 2100 Feb 28", tm(12'h200, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59),
             tm(12'h200, 8'h03, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_year();
        roll("R7 year decimal carry", tm(12'h199, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59),
             tm(12'h200, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00));
        roll("R7 year 999 wrap", tm(12'h999, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59),
             tm(12'h000, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_collide();
        logic [63:0] t;
        set_time(12'h124, 8'h06, 8'h15, 8'h03, 8'h10, 8'h20, 8'h59);
        while (sec_pulse !== 1'b1) @(negedge clk);
        wr(1, 12'h042);
        read_all(t);
        chk("R9 written minute wins, seconds advance", t,
            tm(12'h124, 8'h06, 8'h15, 8'h03, 8'h10, 8'h42, 8'h00));
    endtask

    task automatic t_format();
        logic [11:0] v;
        set_time(12'h987, 8'h12, 8'h05, 8'h04, 8'h09, 8'h08, 8'h07);
        rd(6, v);
        chk("R10 year layout", 64'(v), 64'h987);
        rd(5, v);
        chk("R10 month 12 in BCD", 64'(v), 64'h012);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divider();
        t_off();
        t_carries();
        t_months();
        t_leap();
        t_year();
        t_collide();
        t_format();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule